// File: doc/BRIEF.md
# Length-Limited Vector Byte Mover

This block copies a variable number of bytes between a byte-wide memory port and a 128-bit vector value. A 64-bit length operand supplies the count in its most significant byte, and any count above sixteen is treated as sixteen. A load assembles a new vector that starts at zero, so every lane that receives no memory byte reads as zero. A store emits bytes taken from the vector and leaves every other memory location alone.

Byte placement depends on two controls. In big-endian placement, or whenever the left-justified form is requested, memory bytes fill vector lanes from lane 0 upward. In little-endian placement without left-justification, they fill lanes from lane 15 downward. A store reads lanes in the same order that a load of the same form fills them. Vector lane 0 is bits 127:120. The memory address advances by one per byte. In narrow addressing mode the sum wraps within 32 bits.

A request is accepted with a single-cycle `start` while the block is idle. Each byte moves through a request/acknowledge handshake. A load reports its vector with a one-cycle valid pulse.

Top module: `partial_vec_mover`

## Requirements
- R1: The byte count is bits 63:56 of `len_op`, clamped to 16 when it is 16 or more. Exactly that many memory handshakes complete for the operation.
- R2: A load whose count is zero makes no memory request. It pulses `ld_valid` in the cycle after acceptance, with `ld_data` all zero.
- R3: A store whose count is zero makes no memory request and produces no `ld_valid`. `busy` is low again in the cycle after acceptance.
- R4: In a load result, every lane that received no memory byte is zero.
- R5: When `little_end` is 0, or `left_just` is 1, memory byte i goes to or comes from vector lane i. Lane k occupies bits 127-8k down to 120-8k.
- R6: When `little_end` is 1 and `left_just` is 0, memory byte i goes to or comes from vector lane 15-i.
- R7: A store drives `mem_we`=1 and `mem_wdata` with the lane selected under R5/R6. A load drives `mem_we`=0.
- R8: The first address is `addr` as given. Each later address is the previous address plus one. With `wide_addr`=1 the sum is 64 bits wide. With `wide_addr`=0 it is the low 32 bits of the sum, zero-extended.
- R9: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack` is seen at a clock edge. One byte moves per acknowledged cycle.
- R10: `ld_valid` is high for exactly one cycle, in the cycle after the last acknowledge of a load, with the result on `ld_data`. `mem_req` is low in that cycle.
- R11: `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a new operation when idle |
| is_store | input | 1 | 1 = store, 0 = load |
| little_end | input | 1 | Little-endian placement |
| left_just | input | 1 | Left-justified form; overrides little_end |
| wide_addr | input | 1 | 1 = 64-bit address arithmetic, 0 = 32-bit wrap |
| addr | input | 64 | First memory address |
| len_op | input | 64 | Length operand; count in bits 63:56 |
| vec_in | input | 128 | Vector source for stores |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Request byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request completes at this edge |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| ld_valid | output | 1 | Load result strobe |
| ld_data | output | 128 | Load result |

## Verification
Loads and stores are run with raw counts of 0, short counts, and counts of 16 and above. These separate the clamp from the zero case and from partial fills whose untouched lanes must read zero. Each count is paired with big-endian, little-endian and left-justified-with-little-endian controls, so a mirrored lane order or a left-justified override that is not honoured shows up as a wrong byte in a specific lane. Addresses next to the 32-bit boundary are run in both address modes to tell wrapping apart from carrying. Acknowledge delays of zero to two cycles, plus a `start` pulse during a long transfer, test how the handshake holds and whether a busy-time request is ignored.

// File: rtl/pvm_pkg.sv
package pvm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } pvm_state_e;

endpackage

// File: rtl/pvm_len_clamp.sv
module pvm_len_clamp #(
    parameter int FIELD_W   = 8,
    parameter int VEC_BYTES = 16,
    parameter int CNT_W     = 5
) (
    input  logic [FIELD_W-1:0] field,
    output logic [CNT_W-1:0]   cnt
);

    localparam logic [FIELD_W-1:0] LIMIT_F = FIELD_W'(VEC_BYTES);
    localparam logic [CNT_W-1:0]   LIMIT_C = CNT_W'(VEC_BYTES);

    always_comb begin
        if (field >= LIMIT_F) begin
            cnt = LIMIT_C;
        end else begin
            cnt = CNT_W'(field);
        end
    end

endmodule

// File: rtl/pvm_lane_sel.sv
module pvm_lane_sel #(
    parameter int VEC_BYTES = 16,
    parameter int IDX_W     = 4
) (
    input  logic [VEC_BYTES*8-1:0] vec,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   reverse,
    output logic [IDX_W-1:0]       lane,
    output logic [7:0]             lane_byte
);

    localparam logic [IDX_W-1:0] TOP_LANE = IDX_W'(VEC_BYTES - 1);

    logic [7:0] lanes [VEC_BYTES];

    for (genvar g = 0; g < VEC_BYTES; g++) begin : g_lane
        assign lanes[g] = vec[(VEC_BYTES-1-g)*8 +: 8];
    end

    always_comb begin
        if (reverse) begin
            lane = TOP_LANE - idx;
        end else begin
            lane = idx;
        end
    end

    assign lane_byte = lanes[lane];

endmodule

// File: rtl/pvm_addr_step.sv
module pvm_addr_step #(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              wide,
    output logic [ADDR_W-1:0] nxt
);

    if (ADDR_W > NARROW_W) begin : g_split
        logic [NARROW_W-1:0] low_sum;
        assign low_sum = cur[NARROW_W-1:0] + 1'b1;
        always_comb begin
            if (wide) begin
                nxt = cur + 1'b1;
            end else begin
                nxt = {{(ADDR_W-NARROW_W){1'b0}}, low_sum};
            end
        end
    end else begin : g_flat
        logic unused_wide;
        assign unused_wide = wide;
        assign nxt = cur + 1'b1;
    end

endmodule

// File: rtl/partial_vec_mover.sv
module partial_vec_mover #(
    parameter int ADDR_W    = 64,
    parameter int NARROW_W  = 32,
    parameter int LEN_W     = 64,
    parameter int FIELD_W   = 8,
    parameter int VEC_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   is_store,
    input  logic                   little_end,
    input  logic                   left_just,
    input  logic                   wide_addr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [LEN_W-1:0]       len_op,
    input  logic [VEC_BYTES*8-1:0] vec_in,
    output logic                   busy,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [7:0]             mem_wdata,
    input  logic                   mem_ack,
    input  logic [7:0]             mem_rdata,
    output logic                   ld_valid,
    output logic [VEC_BYTES*8-1:0] ld_data
);

    import pvm_pkg::*;

    localparam int VEC_W = VEC_BYTES * 8;
    localparam int CNT_W = $clog2(VEC_BYTES + 1);
    localparam int IDX_W = $clog2(VEC_BYTES);

    typedef struct packed {
        pvm_state_e        state;
        logic              store;
        logic              rev;
        logic              wide;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [ADDR_W-1:0] addr;
        logic [VEC_W-1:0]  vec;
        logic [VEC_W-1:0]  acc;
    } pvm_regs_t;

    pvm_regs_t r_q, r_d;

    logic [CNT_W-1:0]  start_cnt;
    logic [IDX_W-1:0]  cur_lane;
    logic [7:0]        cur_byte;
    logic [ADDR_W-1:0] next_addr;

    pvm_len_clamp #(
        .FIELD_W  (FIELD_W),
        .VEC_BYTES(VEC_BYTES),
        .CNT_W    (CNT_W)
    ) u_clamp (
        .field(len_op[LEN_W-1 -: FIELD_W]),
        .cnt  (start_cnt)
    );

    pvm_lane_sel #(
        .VEC_BYTES(VEC_BYTES),
        .IDX_W    (IDX_W)
    ) u_lane (
        .vec      (r_q.vec),
        .idx      (r_q.idx),
        .reverse  (r_q.rev),
        .lane     (cur_lane),
        .lane_byte(cur_byte)
    );

    pvm_addr_step #(
        .ADDR_W  (ADDR_W),
        .NARROW_W(NARROW_W)
    ) u_step (
        .cur (r_q.addr),
        .wide(r_q.wide),
        .nxt (next_addr)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.store = is_store;
                    r_d.rev   = little_end & ~left_just;
                    r_d.wide  = wide_addr;
                    r_d.addr  = addr;
                    r_d.vec   = vec_in;
                    r_d.idx   = '0;
                    r_d.acc   = '0;
                    r_d.last  = IDX_W'(start_cnt - 1'b1);
                    if (start_cnt == '0) begin
                        r_d.state = is_store ? ST_IDLE : ST_DONE;
                    end else begin
                        r_d.state = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                if (mem_ack) begin
                    if (!r_q.store) begin
                        for (int k = 0; k < VEC_BYTES; k++) begin
                            if (cur_lane == IDX_W'(k)) begin
                                r_d.acc[(VEC_BYTES-1-k)*8 +: 8] = mem_rdata;
                            end
                        end
                    end
                    r_d.addr = next_addr;
                    r_d.idx  = r_q.idx + 1'b1;
                    if (r_q.idx == r_q.last) begin
                        r_d.state = r_q.store ? ST_IDLE : ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign mem_req   = (r_q.state == ST_XFER);
    assign mem_we    = r_q.store;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = cur_byte;
    assign ld_valid  = (r_q.state == ST_DONE);
    assign ld_data   = r_q.acc;

endmodule

// File: rtl/partial_vec_mover_chk.sv
module partial_vec_mover_chk #(
    parameter int ADDR_W    = 64,
    parameter int NARROW_W  = 32,
    parameter int LEN_W     = 64,
    parameter int FIELD_W   = 8,
    parameter int VEC_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              is_store,
    input logic              wide_addr,
    input logic [LEN_W-1:0]  len_op,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_ack,
    input logic              ld_valid
);

    localparam int CNT_W = $clog2(VEC_BYTES + 1);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'({NARROW_W{1'b1}});

    logic [FIELD_W-1:0] fld;
    logic [CNT_W-1:0]   want_cnt;
    logic [CNT_W-1:0]   exp_cnt;
    logic [CNT_W-1:0]   ack_cnt;
    logic               op_store;
    logic               op_wide;
    logic [ADDR_W-1:0]  nxt_exp;
    logic               accept;

    assign fld      = len_op[LEN_W-1 -: FIELD_W];
    assign want_cnt = (fld > FIELD_W'(VEC_BYTES - 1)) ? CNT_W'(VEC_BYTES) : CNT_W'(fld);
    assign accept   = start && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_cnt  <= '0;
            ack_cnt  <= '0;
            op_store <= 1'b0;
            op_wide  <= 1'b0;
            nxt_exp  <= '0;
        end else begin
            if (accept) begin
                exp_cnt  <= want_cnt;
                ack_cnt  <= '0;
                op_store <= is_store;
                op_wide  <= wide_addr;
            end else if (mem_req && mem_ack) begin
                ack_cnt <= ack_cnt + 1'b1;
            end
            if (mem_req && mem_ack) begin
                nxt_exp <= op_wide ? (mem_addr + 1'b1) : ((mem_addr + 1'b1) & LOW_MASK);
            end
        end
    end

    // R9
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R10
    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid);

    a_r10_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> !mem_req);

    // R8
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req || mem_addr == nxt_exp));

    // R1
    a_r1_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ack_cnt == exp_cnt));

    // R3
    a_r3_zero_store: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_store && fld == '0) |=> !busy);

    // R7
    a_r7_store_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> !op_store);

    a_r7_we_kind: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_we == op_store));

endmodule

bind partial_vec_mover partial_vec_mover_chk #(
    .ADDR_W   (ADDR_W),
    .NARROW_W (NARROW_W),
    .LEN_W    (LEN_W),
    .FIELD_W  (FIELD_W),
    .VEC_BYTES(VEC_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_store (is_store),
    .wide_addr(wide_addr),
    .len_op   (len_op),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .ld_valid (ld_valid)
);

// File: tb/partial_vec_mover_test.sv
module partial_vec_mover_test;

    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_store = 1'b0;
    logic         little_end = 1'b0;
    logic         left_just = 1'b0;
    logic         wide_addr = 1'b0;
    logic [63:0]  addr = '0;
    logic [63:0]  len_op = '0;
    logic [127:0] vec_in = '0;
    logic         busy;
    logic         mem_req;
    logic         mem_we;
    logic [63:0]  mem_addr;
    logic [7:0]   mem_wdata;
    logic         mem_ack = 1'b0;
    logic [7:0]   mem_rdata = '0;
    logic         ld_valid;
    logic [127:0] ld_data;

    partial_vec_mover uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
        .little_end(little_end), .left_just(left_just), .wide_addr(wide_addr),
        .addr(addr), .len_op(len_op), .vec_in(vec_in), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    always #(CLK_NS/2) clk = ~clk;

    logic [63:0]  q_addr[$];
    bit           q_we[$];
    logic [7:0]   q_wd[$];
    bit           pend_ld = 0;
    logic [127:0] exp_ld = '0;
    string        ld_tag = "R4";
    bit           acked = 0;
    bit           live = 0;
    int           wait_cfg = 0;
    int           wcnt = 0;
    int           n_vec = 0;
    int           n_bad = 0;

    function automatic logic [7:0] mem_fn(logic [63:0] a);
        return 8'(a[7:0] * 8'd29) ^ a[15:8] ^ {4'h0, a[35:32]} ^ 8'h6B;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // reference model, compared at every falling edge
    always @(negedge clk) begin
        if (live) begin
            if (acked) begin
                void'(q_addr.pop_front());
                void'(q_we.pop_front());
                void'(q_wd.pop_front());
            end
            acked = 0;
            chk(busy == (q_addr.size() != 0 || pend_ld), "R11", "busy", 128'(busy),
                128'(q_addr.size() != 0 || pend_ld));
            chk(mem_req == (q_addr.size() != 0), "R1", "mem_req", 128'(mem_req),
                128'(q_addr.size() != 0));
            if (q_addr.size() != 0 && mem_req) begin
                chk(mem_addr == q_addr[0], "R8", "mem_addr", 128'(mem_addr), 128'(q_addr[0]));
                chk(mem_we == q_we[0], "R7", "mem_we", 128'(mem_we), 128'(q_we[0]));
                if (q_we[0])
                    chk(mem_wdata == q_wd[0], "R7", "mem_wdata", 128'(mem_wdata), 128'(q_wd[0]));
            end
            chk(ld_valid == (q_addr.size() == 0 && pend_ld), "R10", "ld_valid", 128'(ld_valid),
                128'(q_addr.size() == 0 && pend_ld));
            if (q_addr.size() == 0 && pend_ld) begin
                chk(ld_data == exp_ld, ld_tag, "ld_data", ld_data, exp_ld);
                pend_ld = 0;
            end
            if (mem_req && q_addr.size() != 0) begin
                if (wcnt >= wait_cfg) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem_fn(mem_addr);
                    acked = 1;
                    wcnt = 0;
                end else begin
                    mem_ack = 1'b0;
                    wcnt++;
                end
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    task automatic wait_idle();
        forever begin
            @(negedge clk);
            #2;
            if (q_addr.size() == 0 && !pend_ld && !busy) break;
        end
    endtask

    task automatic run_op(logic [63:0] a, logic [7:0] nf, bit st, bit le, bit lj, bit wd,
                          logic [127:0] v, int wt, bit poke, string tag);
        int n;
        int lane;
        logic [63:0] cur;
        wait_idle();
        wait_cfg = wt;
        wcnt = 0;
        addr = a; len_op = {nf, 56'h5A_A5_12_34_56_78_9A}; is_store = st;
        little_end = le; left_just = lj; wide_addr = wd; vec_in = v;
        start = 1'b1;
        n = (nf >= 8'd16) ? 16 : int'(nf);
        cur = a;
        exp_ld = '0;
        for (int i = 0; i < n; i++) begin
            lane = (le && !lj) ? 15 - i : i;
            q_addr.push_back(cur);
            q_we.push_back(st);
            q_wd.push_back(v[127 - 8*lane -: 8]);
            exp_ld[127 - 8*lane -: 8] = mem_fn(cur);
            cur = wd ? cur + 64'd1 : {32'h0, cur[31:0] + 32'd1};
        end
        pend_ld = !st;
        ld_tag = tag;
        @(negedge clk);
        #2;
        start = 1'b0;
        if (poke) begin
            // R11: a request while busy must change nothing
            addr = 64'hDEAD_0000; len_op = {8'd3, 56'h0}; is_store = ~st;
            little_end = ~le; vec_in = ~v;
            start = 1'b1;
            @(negedge clk);
            #2;
            start = 1'b0;
        end
    endtask

    localparam logic [127:0] VA = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    localparam logic [127:0] VB = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;

    initial begin
        repeat (3) @(negedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // reset state
        chk(!busy && !mem_req && !ld_valid, "R9", "idle after reset", 128'({busy, mem_req, ld_valid}), 128'(0));
        chk(ld_data == '0, "R10", "ld_data after reset", ld_data, '0);
        live = 1;
        run_op(64'h100, 8'd4, 0, 0, 0, 1, '0, 0, 0, "R4");          // R4 R5 short BE load
        run_op(64'h240, 8'd5, 0, 1, 0, 1, '0, 1, 0, "R6");          // R6 LE load
        run_op(64'h300, 8'd7, 0, 1, 1, 1, '0, 2, 0, "R5");          // R5 left-justified overrides LE
        run_op(64'h410, 8'h13, 0, 0, 0, 1, '0, 0, 1, "R1");         // R1 clamp, R11 poke
        run_op(64'h520, 8'hFF, 0, 1, 0, 1, '0, 1, 0, "R1");         // R1 clamp LE
        run_op(64'h600, 8'd0, 0, 1, 0, 1, '0, 0, 0, "R2");          // R2 zero load
        run_op(64'h700, 8'd0, 1, 0, 0, 1, VA, 0, 0, "R3");          // R3 zero store
        run_op(64'h800, 8'd3, 1, 0, 0, 1, VA, 1, 0, "R7");          // R7 BE store
        run_op(64'h900, 8'd9, 1, 1, 0, 1, VB, 0, 1, "R6");          // R6 LE store, R11
        run_op(64'hA00, 8'd16, 1, 1, 1, 1, VB, 2, 0, "R5");         // R5 LJ store
        run_op(64'hFFFF_FFFE, 8'd4, 0, 0, 0, 0, '0, 0, 0, "R8");    // R8 narrow wrap
        run_op(64'hFFFF_FFFE, 8'd4, 0, 1, 0, 1, '0, 1, 0, "R8");    // R8 wide carry
        run_op(64'hFFFF_FFFD, 8'd6, 1, 0, 0, 0, VA, 0, 0, "R8");    // R8 narrow store
        run_op(64'h0123_4567_0000_0010, 8'd2, 0, 0, 0, 1, '0, 0, 0, "R4"); // R4 two lanes
        wait_idle();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog expired: got %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule